// File: doc/BRIEF.md
# Diagonal Token Matching Allocator

This block pairs N requesters with N resources in a single cycle. Each requester presents one request bit per resource, forming an N×N request matrix. A square array of cells decides every match in the same pass: each row carries a token for its requester and each column a token for its resource. Tokens enter along one priority diagonal and travel one diagonal at a time. A cell that sees a request and still holds both of its tokens takes the match and retires both tokens. Otherwise the row token moves one cell to the right and the column token one cell down, with wrap-around in both directions. After N diagonal steps every cell has been visited. Because the wrap-around is unrolled into N fixed steps, the logic has no combinational loop.

The result is registered into an N×N grant matrix. The grant matrix has no more than one bit set in any row or any column. It is also maximal: a request is left unserved only because its row or its column already holds a grant. A priority diagonal register moves forward by one after every cycle that issues a grant, so each requester takes its turn at the head of the order.

Top module: `wavefront_alloc`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `grant_o` is all zeros. The priority diagonal restarts at 0.
- R2: `grant_o` never has more than one bit set in any row (requester) or in any column (resource).
- R3: A grant bit is set only where the request matrix sampled on the same clock edge had its bit set. Request bit `i*N+j` means that requester i asks for resource j, and grant bit `i*N+j` uses the same encoding.
- R4: The grant matrix is maximal. For every sampled request (i,j), either row i or column j of `grant_o` holds a grant.
- R5: Diagonal k is the set of cells (i,j) with (i+j) mod N = k. With priority diagonal p, diagonals p, p+1, …, p+N−1 (mod N) are processed in that order. For example, with N=4, p=0 and request 0x5137, the grant is 0x4021.
- R6: The priority diagonal advances by one, wrapping from N−1 to 0, after each cycle whose grant matrix is non-zero. It holds its value after a cycle with no grant.
- R7: The grant for a request matrix appears on `grant_o` after the clock edge that samples the request, and it stays until the next edge.
- R8: Cells on the priority diagonal win over every other cell in their row and column. For example, with N=4 and p=2, a full column-0 request 0x1111 grants only requester 2 (0x0100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N*N | Request matrix, bit i*N+j = requester i wants resource j |
| grant_o | output | N*N | Registered grant matrix, same encoding as req_i |

## Verification
The priority diagonal is the only state in the block. If it is wrong, a request pattern with contention hands its grants to the wrong requesters, and this shows on `grant_o` on the first such pattern after the error. A diagonal that fails to advance, or advances by the wrong step, leaves grants that are still legal and maximal but differ from the expected order. For that reason the bench tracks the diagonal on its own and compares every grant matrix exactly, and does not check only legality. A wrong token-passing path shows up as a double grant in a row or column, or as an unserved request whose row and column are both free. Either appears on the same cycle's output.

// File: rtl/wf_pkg.sv
package wf_pkg;

  // Column visited by row i at unrolled step s when diagonal p leads.
  function automatic int unsigned diag_col(int unsigned p, int unsigned s,
                                           int unsigned i, int unsigned n);
    return (p + s + n - i) % n;
  endfunction

  // Next priority diagonal with wrap at n.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wf_prio_ptr.sv
module wf_prio_ptr #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  output logic [PW-1:0] prio_o
);
  import wf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)
      prio_o <= '0;
    else if (adv_i)
      prio_o <= PW'(wrap_inc(int'(prio_o), N));
  end

endmodule

// File: rtl/wf_array.sv
module wf_array #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic [PW-1:0] prio_i,
  input  logic [NN-1:0] req_i,
  output logic [NN-1:0] gnt_o,
  output logic          any_o
);
  import wf_pkg::*;

  logic [N-1:0] row_tok;
  logic [N-1:0] col_tok;

  // Unrolled wave: step s visits diagonal (prio+s) mod N; each row
  // touches exactly one column per step, so rows in a step never collide.
  always_comb begin
    row_tok = '1;
    col_tok = '1;
    gnt_o   = '0;
    for (int s = 0; s < N; s++) begin
      for (int i = 0; i < N; i++) begin
        int unsigned jj;
        jj = diag_col(int'(prio_i), s, i, N);
        if (req_i[i*N + jj] && row_tok[i] && col_tok[jj]) begin
          gnt_o[i*N + jj] = 1'b1;
          row_tok[i]      = 1'b0;
          col_tok[jj]     = 1'b0;
        end
      end
    end
    any_o = |gnt_o;
  end

endmodule

// File: rtl/wavefront_alloc.sv
module wavefront_alloc #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NN-1:0] req_i,
  output logic [NN-1:0] grant_o
);

  logic [PW-1:0] prio_q;
  logic [NN-1:0] gnt_c;
  logic          any_c;

  wf_array #(.N(N)) array_i (
    .prio_i (prio_q),
    .req_i  (req_i),
    .gnt_o  (gnt_c),
    .any_o  (any_c)
  );

  wf_prio_ptr #(.N(N)) ptr_i (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (any_c),
    .prio_o (prio_q)
  );

  always_ff @(posedge clk) begin
    if (rst) grant_o <= '0;
    else     grant_o <= gnt_c;
  end

endmodule

// File: rtl/wf_alloc_chk.sv
module wf_alloc_chk #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input logic          clk,
  input logic          rst,
  input logic [NN-1:0] req_i,
  input logic [NN-1:0] grant_o,
  input logic [PW-1:0] prio_q
);

  function automatic logic [N-1:0] row_of(logic [NN-1:0] m, int r);
    for (int c = 0; c < N; c++) row_of[c] = m[r*N + c];
  endfunction

  function automatic logic [N-1:0] col_of(logic [NN-1:0] m, int c);
    for (int r = 0; r < N; r++) col_of[r] = m[r*N + c];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grant_o == '0 && prio_q == '0)); // R1

  generate
    for (genvar k = 0; k < N; k++) begin : g_lines
      AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_of(grant_o, k))); // R2
      AST_COL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_of(grant_o, k))); // R2
    end
    for (genvar b = 0; b < NN; b++) begin : g_cells
      AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        grant_o[b] |-> $past(req_i[b])); // R3
      AST_MAXIMAL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_i[b]))
          |-> (|row_of(grant_o, b / N) || |col_of(grant_o, b % N))); // R4
    end
  endgenerate

  AST_PRIO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |grant_o)
      |-> prio_q == (($past(prio_q) == PW'(N-1)) ? '0 : $past(prio_q) + 1'b1)); // R6

  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0) |-> $stable(prio_q)); // R6

endmodule

bind wavefront_alloc wf_alloc_chk #(.N(N)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .req_i   (req_i),
  .grant_o (grant_o),
  .prio_q  (prio_q)
);

// File: tb/wavefront_alloc_tb_top.sv
module wavefront_alloc_tb_top;
  localparam int N  = 4;
  localparam int NN = N * N;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NN-1:0] req = '0;
  logic [NN-1:0] grant_o;

  int n_chk  = 0;
  int n_fail = 0;
  int prio_m = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wavefront_alloc #(.N(N)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req),
    .grant_o (grant_o)
  );

  // {request, expected grant}, applied in order from reset (diagonal 0)
  localparam logic [31:0] VEC [NV] = '{
    {16'h5137, 16'h4021},  // R5 worked example, p=0
    {16'hFFFF, 16'h4812},  // R5 full matrix, p=1
    {16'h0000, 16'h0000},  // R6 no grant, p stays 2
    {16'h1111, 16'h0100},  // R8 column contention, p=2
    {16'h1111, 16'h1000},  // R8 p=3
    {16'h000F, 16'h0001},  // R6 wrap to p=0
    {16'h0023, 16'h0002},  // R4 maximal, not maximum, p=1
    {16'h8421, 16'h8421}   // R5 p=2
  };

  function automatic logic [NN-1:0] model(logic [NN-1:0] r, int p);
    bit rfree [N];
    bit cfree [N];
    logic [NN-1:0] g = '0;
    for (int i = 0; i < N; i++) begin rfree[i] = 1; cfree[i] = 1; end
    for (int s = 0; s < N; s++) begin
      int d = (p + s) % N;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if ((i + j) % N == d && r[i*N+j] && rfree[i] && cfree[j]) begin
            g[i*N+j] = 1'b1; rfree[i] = 0; cfree[j] = 0;
          end
    end
    return g;
  endfunction

  task automatic check(string tag, logic [NN-1:0] act, logic [NN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic legal(logic [NN-1:0] r, logic [NN-1:0] g);
    bit ok2 = 1, ok3 = 1, ok4 = 1;
    for (int k = 0; k < N; k++) begin
      int rc = 0, cc = 0;
      for (int m = 0; m < N; m++) begin rc += g[k*N+m]; cc += g[m*N+k]; end
      if (rc > 1 || cc > 1) ok2 = 0;
    end
    if ((g & ~r) != '0) ok3 = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (r[i*N+j]) begin
          bit hit = 0;
          for (int m = 0; m < N; m++) hit |= g[i*N+m] | g[m*N+j];
          if (!hit) ok4 = 0;
        end
    check("R2 single per row/col", {15'd0, ok2}, 16'd1);
    check("R3 grant needs request", {15'd0, ok3}, 16'd1);
    check("R4 maximal", {15'd0, ok4}, 16'd1);
  endtask

  task automatic apply(logic [NN-1:0] r, logic [NN-1:0] exp, string tag);
    logic [NN-1:0] exp_m;
    @(negedge clk);
    req = r;
    exp_m = model(r, prio_m);
    @(posedge clk);
    #1;
    check(tag, grant_o, exp);
    check("R7 model match", grant_o, exp_m);
    legal(r, grant_o);
    if (exp_m != '0) prio_m = (prio_m + 1) % N;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    req = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1 grant clear in reset", grant_o, '0);
    @(negedge clk);
    rst = 1'b0;
    req = '0;
    @(posedge clk);
    #1;
    check("R1 grant clear after reset", grant_o, '0);

    for (int v = 0; v < NV; v++)
      apply(VEC[v][31:16], VEC[v][15:0], $sformatf("R5/R6/R8 vector %0d", v));

    // R7: output holds between edges
    @(negedge clk);
    check("R7 hold to next edge", grant_o, 16'h8421);

    // R1: mid-run reset returns priority to diagonal 0
    @(negedge clk);
    rst = 1'b1; req = 16'hFFFF;
    @(posedge clk);
    #1;
    check("R1 grant clear in mid reset", grant_o, '0);
    @(negedge clk);
    rst = 1'b0;
    prio_m = 0;
    req = '0;
    @(posedge clk);
    apply(16'hFFFF, 16'h2481, "R1 diagonal 0 after reset");

    // Pseudo-random patterns against the model
    for (int t = 0; t < 200; t++) begin
      logic [NN-1:0] e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e = model(lfsr & {lfsr[7:0], lfsr[15:8]}, prio_m);
      apply(lfsr & {lfsr[7:0], lfsr[15:8]}, e, "R5/R6 random");
    end

    done = 1'b1;
    summary();
  end

endmodule